// File: doc/BRIEF.md
# Presettable Binary/Decade Up/Down Counter

This block is a chain of four-bit counting digits that share one clock. Each digit counts in straight binary (modulo 16) or in decade form (modulo 10), upward or downward. A preset line loads the whole chain from a set of parallel load inputs. The load acts at once and does not wait for a clock edge. An active-low count enable enters the least significant digit. Each digit passes an active-low terminal-count flag to the next digit as that digit's enable. The chain therefore counts as one multi-digit number, in hexadecimal or packed BCD.

The terminal flag is purely combinational. The enable path therefore ripples through every digit within a single clock period, and all digits update on the same rising edge. The last digit's flag is brought out. This lets the chain extend a wider counter or act as a terminal-count event. The block has no streaming data path, so every pin is a plain level-sensitive control or status signal.

Top module: `updn_cnt_chain`

## Requirements
- R1: While `preset_en` is high, `q` equals `load_val` without waiting for a clock edge, and it keeps that value across clock edges for as long as `preset_en` stays high. With `load_val` all zero, `q` is zero.
- R2: On a rising edge of `clk` with `preset_en` low and `en_n` low, the count moves by exactly one step. `q` does not change between clock edges unless `preset_en` is high.
- R3: On a rising edge with `en_n` high, `q` does not change.
- R4: In binary mode (`bin_mode` = 1), each digit counts modulo 16. Counting up, 15 goes to 0; counting down, 0 goes to 15. `count_up` = 1 selects up and 0 selects down.
- R5: In decade mode (`bin_mode` = 0), counting up takes 9 to 0, and counting down takes 0 to 9.
- R6: In decade up mode, a digit that holds an out-of-range value from 10 to 15 goes to 0 on the next enabled edge. That digit does not enable the next digit.
- R7: `term_n` is low only when `en_n` is low and every digit is at its terminal value: 15 in binary up, 9 in decade up, 0 when counting down in either mode. Otherwise `term_n` is high.
- R8: Digit k (k > 0) is enabled only when every lower digit is at its terminal value. Bits [4k+3:4k] of `q` form digit k. The chain therefore counts as one number, in hexadecimal (binary mode) or packed BCD (decade mode). For example, 0x0F goes to 0x10 in binary up, 0x19 goes to 0x20 in decade up, and 0x10 goes to 0x09 in decade down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Count clock; all digits step on its rising edge |
| preset_en | input | 1 | Asynchronous, level-sensitive load of `load_val` into the count |
| load_val | input | 4*NUM_DIGITS | Parallel load value; digit k is bits [4k+3:4k] |
| en_n | input | 1 | Active-low count enable into the least significant digit |
| bin_mode | input | 1 | 1 selects modulo 16 per digit, 0 selects modulo 10 |
| count_up | input | 1 | 1 counts up, 0 counts down |
| q | output | 4*NUM_DIGITS | Count value, least significant digit in bits [3:0] |
| term_n | output | 1 | Active-low terminal-count flag of the most significant digit |

## Verification
The count is exercised from loaded values just below each wrap point in all four combinations of modulus and direction.

- **Wrap points.** Tests cover 0x0E and 0xFF in binary up, 0x10 and 0x00 in binary down, 0x98 and 0x19 in decade up, and 0x00 and 0x10 in decade down. Each of these separates a digit-local wrap from a carry or borrow into the upper digit. Each also separates a modulo 16 wrap from a modulo 10 wrap.
- **Out-of-range decade digit.** A low digit loaded with 12 in decade up mode shows the forced return to zero. It also shows that this case does not enable the upper digit.
- **Enable and preset inhibits.** Tests hold the enable high, and hold the preset high across edges, to show that both inhibits block counting.
- **Asynchronous load.** The load is observed between clock edges to show that it does not wait for the clock.
- **Terminal flag.** The flag is sampled at all-terminal values, with the enable low and then high, to separate the terminal decode from its enable gating.

// File: rtl/updn_cnt_pkg.sv
package updn_cnt_pkg;
  localparam int DIGIT_W   = 4;
  localparam int BIN_LAST  = (1 << DIGIT_W) - 1;
  localparam int DEC_LAST  = 9;

  typedef logic [DIGIT_W-1:0] digit_t;

  typedef enum logic {
    MOD_DEC = 1'b0,
    MOD_BIN = 1'b1
  } modulus_e;

  typedef enum logic {
    DIR_DOWN = 1'b0,
    DIR_UP   = 1'b1
  } direction_e;
endpackage

// File: rtl/updn_step_logic.sv
module updn_step_logic
  import updn_cnt_pkg::*;
(
  input  digit_t     cur,
  input  modulus_e   modulus,
  input  direction_e dir,
  output digit_t     nxt,
  output logic       at_term
);
  localparam digit_t BIN_TOP = digit_t'(BIN_LAST);
  localparam digit_t DEC_TOP = digit_t'(DEC_LAST);
  localparam digit_t ZERO    = '0;
  localparam digit_t ONE     = digit_t'(1);

  logic at_zero;
  logic at_dec_top_or_above;
  logic up_top;

  assign at_zero             = (cur == ZERO);
  assign at_dec_top_or_above = (cur >= DEC_TOP);
  assign up_top              = (modulus == MOD_BIN) ? (cur == BIN_TOP) : (cur == DEC_TOP);

  always_comb begin
    nxt = cur;
    unique case (dir)
      DIR_UP: begin
        if (modulus == MOD_DEC && at_dec_top_or_above) nxt = ZERO;
        else                                           nxt = cur + ONE;
      end
      DIR_DOWN: begin
        if (modulus == MOD_DEC && at_zero) nxt = DEC_TOP;
        else                               nxt = cur - ONE;
      end
      default: nxt = cur;
    endcase
  end

  assign at_term = (dir == DIR_UP) ? up_top : at_zero;
endmodule

// File: rtl/updn_digit.sv
module updn_digit
  import updn_cnt_pkg::*;
(
  input  logic       clk,
  input  logic       preset_en,
  input  digit_t     load_val,
  input  logic       en_n,
  input  modulus_e   modulus,
  input  direction_e dir,
  output digit_t     q,
  output logic       term_n
);
  digit_t nxt;
  logic   at_term;

  updn_step_logic u_step (
    .cur     (q),
    .modulus (modulus),
    .dir     (dir),
    .nxt     (nxt),
    .at_term (at_term)
  );

  // Asynchronous level load takes priority over the clocked step.
  always_ff @(posedge clk or posedge preset_en) begin
    if (preset_en)  q <= load_val;
    else if (!en_n) q <= nxt;
  end

  assign term_n = ~(~en_n & at_term);
endmodule

// File: rtl/updn_cnt_chain.sv
module updn_cnt_chain
  import updn_cnt_pkg::*;
#(
  parameter int NUM_DIGITS = 2,
  localparam int CW = NUM_DIGITS * DIGIT_W
) (
  input  logic          clk,
  input  logic          preset_en,
  input  logic [CW-1:0] load_val,
  input  logic          en_n,
  input  logic          bin_mode,
  input  logic          count_up,
  output logic [CW-1:0] q,
  output logic          term_n
);
  modulus_e   modulus;
  direction_e dir;
  logic [NUM_DIGITS:0] link_n;

  assign modulus   = modulus_e'(bin_mode);
  assign dir       = direction_e'(count_up);
  assign link_n[0] = en_n;

  for (genvar k = 0; k < NUM_DIGITS; k++) begin : g_digit
    updn_digit u_digit (
      .clk       (clk),
      .preset_en (preset_en),
      .load_val  (load_val[k*DIGIT_W +: DIGIT_W]),
      .en_n      (link_n[k]),
      .modulus   (modulus),
      .dir       (dir),
      .q         (q[k*DIGIT_W +: DIGIT_W]),
      .term_n    (link_n[k+1])
    );
  end

  assign term_n = link_n[NUM_DIGITS];
endmodule

// File: rtl/updn_cnt_chain_chk.sv
module updn_cnt_chain_chk #(
  parameter int NUM_DIGITS = 2,
  localparam int CW = NUM_DIGITS * 4
) (
  input logic          clk,
  input logic          preset_en,
  input logic [CW-1:0] load_val,
  input logic          en_n,
  input logic          bin_mode,
  input logic          count_up,
  input logic [CW-1:0] q,
  input logic          term_n
);
  logic armed = 1'b0;
  always_ff @(posedge clk) if (preset_en) armed <= 1'b1;

  AST_PRESET_HOLDS: assert property (@(posedge clk) disable iff (!armed)
    preset_en |-> (q == load_val)); // R1

  AST_INHIBIT_HOLD: assert property (@(posedge clk) disable iff (!armed)
    (!preset_en && $past(!preset_en) && $past(en_n)) |-> (q == $past(q))); // R3

  AST_BIN_UP_STEP: assert property (@(posedge clk) disable iff (!armed)
    (!preset_en && $past(!preset_en && !en_n && bin_mode && count_up))
      |-> (q == CW'($past(q) + 1'b1))); // R4

  AST_BIN_DOWN_STEP: assert property (@(posedge clk) disable iff (!armed)
    (!preset_en && $past(!preset_en && !en_n && bin_mode && !count_up))
      |-> (q == CW'($past(q) - 1'b1))); // R8

  AST_DEC_UP_RANGE: assert property (@(posedge clk) disable iff (!armed)
    (!preset_en && $past(!preset_en && !en_n && !bin_mode && count_up))
      |-> (q[3:0] <= 4'd9)); // R6

  AST_EN_BLOCKS_TERM: assert property (@(posedge clk) disable iff (!armed)
    en_n |-> term_n); // R7

  AST_BIN_TOP_TERM: assert property (@(posedge clk) disable iff (!armed)
    (!en_n && bin_mode && count_up && (&q)) |-> !term_n); // R7
endmodule

bind updn_cnt_chain updn_cnt_chain_chk #(.NUM_DIGITS(NUM_DIGITS)) u_chk (
  .clk       (clk),
  .preset_en (preset_en),
  .load_val  (load_val),
  .en_n      (en_n),
  .bin_mode  (bin_mode),
  .count_up  (count_up),
  .q         (q),
  .term_n    (term_n)
);

// File: tb/updn_cnt_chain_tb.sv
module updn_cnt_chain_tb;
  localparam int ND = 2;
  localparam int CW = ND * 4;

  logic          clk = 1'b0;
  logic          preset_en;
  logic [CW-1:0] load_val;
  logic          en_n;
  logic          bin_mode;
  logic          count_up;
  logic [CW-1:0] q;
  logic          term_n;

  int checks   = 0;
  int failures = 0;

  always #10 clk = ~clk;

  updn_cnt_chain #(.NUM_DIGITS(ND)) u_dut (
    .clk(clk), .preset_en(preset_en), .load_val(load_val), .en_n(en_n),
    .bin_mode(bin_mode), .count_up(count_up), .q(q), .term_n(term_n)
  );

  task automatic chk(string req, logic [CW-1:0] act, logic [CW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Load holds across one rising edge, then releases.
  task automatic load(logic [CW-1:0] v);
    load_val  = v;
    preset_en = 1'b1;
    step();
    preset_en = 1'b0;
  endtask

  task automatic t_reset();
    preset_en = 1'b1; load_val = '0; en_n = 1'b1; bin_mode = 1'b1; count_up = 1'b1;
    step();
    chk("R1 zero load", q, '0);
    chk("R7 idle term_n", CW'(term_n), CW'(1));
    preset_en = 1'b0;
  endtask

  task automatic t_preset_async();
    en_n = 1'b0; bin_mode = 1'b1; count_up = 1'b1;
    #3;
    load_val = 8'h5A; preset_en = 1'b1;
    #2;
    chk("R1 load between edges", q, 8'h5A);
    @(negedge clk);
    step(); step();
    chk("R1 held across edges", q, 8'h5A);
    preset_en = 1'b0;
  endtask

  task automatic t_inhibit();
    en_n = 1'b1;
    step(); step(); step();
    chk("R3 enable high holds", q, 8'h5A);
    chk("R7 term_n high when disabled", CW'(term_n), CW'(1));
  endtask

  task automatic t_bin_up();
    en_n = 1'b1; bin_mode = 1'b1; count_up = 1'b1;
    load(8'h0E);
    en_n = 1'b0;
    step();
    chk("R2 single step", q, 8'h0F);
    chk("R7 upper not terminal", CW'(term_n), CW'(1));
    step();
    chk("R8 binary carry", q, 8'h10);
    en_n = 1'b1; load(8'hFF); en_n = 1'b0;
    #1 chk("R7 binary up top", CW'(term_n), CW'(0));
    step();
    chk("R4 binary up wrap", q, 8'h00);
    en_n = 1'b1;
    load(8'hFF);
    #1 chk("R7 enable gates term_n", CW'(term_n), CW'(1));
  endtask

  task automatic t_bin_down();
    en_n = 1'b1; bin_mode = 1'b1; count_up = 1'b0;
    load(8'h10); en_n = 1'b0;
    step();
    chk("R8 binary borrow", q, 8'h0F);
    en_n = 1'b1; load(8'h00); en_n = 1'b0;
    #1 chk("R7 down minimum", CW'(term_n), CW'(0));
    step();
    chk("R4 binary down wrap", q, 8'hFF);
  endtask

  task automatic t_dec_up();
    en_n = 1'b1; bin_mode = 1'b0; count_up = 1'b1;
    load(8'h98); en_n = 1'b0;
    step();
    chk("R5 decade step", q, 8'h99);
    #1 chk("R7 decade up top", CW'(term_n), CW'(0));
    step();
    chk("R5 decade up wrap", q, 8'h00);
    en_n = 1'b1; load(8'h19); en_n = 1'b0;
    step();
    chk("R8 decade carry", q, 8'h20);
  endtask

  task automatic t_dec_down();
    en_n = 1'b1; bin_mode = 1'b0; count_up = 1'b0;
    load(8'h00); en_n = 1'b0;
    step();
    chk("R5 decade down wrap", q, 8'h99);
    en_n = 1'b1; load(8'h10); en_n = 1'b0;
    step();
    chk("R8 decade borrow", q, 8'h09);
  endtask

  task automatic t_dec_range();
    en_n = 1'b1; bin_mode = 1'b0; count_up = 1'b1;
    load(8'h3C); en_n = 1'b0;
    #1 chk("R7 out-of-range not terminal", CW'(term_n), CW'(1));
    step();
    chk("R6 out-of-range to zero", q, 8'h30);
    en_n = 1'b1;
  endtask

  initial begin
    #(20 * 5000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_preset_async();
    t_inhibit();
    t_bin_up();
    t_bin_down();
    t_dec_up();
    t_dec_down();
    t_dec_range();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule